// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Recency Index

This block translates virtual addresses to physical addresses through a small, fully associative table. Each entry maps one virtual page to one physical page and carries its own page size. A lookup request presented in one cycle is answered in the next with a hit and a physical address, a miss, or a multiple-match error. No hardware walks page tables. A miss raises a pending trap flag and captures the offending virtual address, and the flag stays up until software acknowledges it.

Trap software refills the table through a write port that can target any entry index. To choose which entry to overwrite, software reads a recency index that always names the least recently used entry. An entry counts as used when a lookup hits it uniquely or when software writes it. The entry count (64 by default, 16 in a reduced build) and the supported page size range are parameters. Page sizes run in powers of two from 1 KB up to a maximum of 8 KB by default.

Top module: `tlb_xlate`

## Requirements
- R1: While reset is held, and after it is released, rsp_valid and miss_pend are 0 and lru_idx equals NUM_ENTRIES-1. The reset recency order runs from entry 0, most recent, to entry NUM_ENTRIES-1, least recent.
- R2: A lookup request (lk_req=1) produces rsp_valid=1 exactly one cycle later. If exactly one valid entry matches, rsp_hit=1 and rsp_pa holds that entry's physical page with the page offset copied from lk_va.
- R3: Page size code s (wr_size, 0..MAX_PAGE_LOG2-MIN_PAGE_LOG2) selects a page of 2^(10+s) bytes. The low s bits of the stored virtual page number are ignored in the compare. The low s bits of the stored physical page number are replaced by the matching lk_va bits.
- R4: A lookup that matches no valid entry answers with rsp_hit=0, rsp_mhit=0 and rsp_pa=0. In the same cycle miss_pend goes to 1 and fault_va shows the missing virtual address, provided no miss was already pending.
- R5: While miss_pend is 1 and miss_ack is not asserted, further misses leave fault_va unchanged. A miss_ack with no new miss clears miss_pend in the following cycle.
- R6: A write (wr_en=1) loads wr_valid, wr_vpn, wr_ppn and wr_size into entry wr_idx. wr_valid=0 removes the mapping. A lookup in the same cycle as the write still sees the old contents, and lookups from the next cycle see the new ones.
- R7: When two or more valid entries match, the response shows rsp_mhit=1, rsp_hit=0 and rsp_pa=0, and no miss is raised.
- R8: lru_idx names the least recently used entry. A unique hit or a software write makes that entry the most recent. Misses, multiple matches and idle cycles leave the order unchanged.
- R9: If a unique hit and a software write fall in the same cycle, only the written entry is made most recent.
- R10: If miss_ack and a new miss fall in the same cycle, miss_pend stays 1 and fault_va takes the new missing address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Unique match found |
| rsp_mhit | output | 1 | Multiple entries matched |
| rsp_pa | output | PA_W | Translated physical address, zero without a unique hit |
| miss_pend | output | 1 | Miss trap pending |
| fault_va | output | VA_W | Captured virtual address of the pending miss |
| miss_ack | input | 1 | Software acknowledge of the miss trap |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_valid | input | 1 | Valid bit for the written entry |
| wr_vpn | input | VA_W-MIN_PAGE_LOG2 | Virtual page number (1 KB units) |
| wr_ppn | input | PA_W-MIN_PAGE_LOG2 | Physical page number (1 KB units) |
| wr_size | input | SZ_W | Page size code |
| lru_idx | output | IDX_W | Least recently used entry index |

## Verification
Two pairs of functions can land in the same cycle. The first is a software write and a unique hit, since both want to update the recency order. The bench first writes every entry in index order, so the recency order becomes known. It then issues a hit on the least recent entry together with a write to another entry. The recency index must stay on the hit entry, and the hit must return the translation that was in place before the write. The second pair is an acknowledge and a new miss. Here the pending flag must stay set and the captured address must switch to the new fault.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Bits needed to encode n distinct values, never less than one.
  function automatic int enc_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/tlb_entry.sv
module tlb_entry #(
  parameter int TW   = 22,
  parameter int PW   = 22,
  parameter int SZ_W = 2,
  parameter int MAXC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            wr_valid,
  input  logic [TW-1:0]   wr_vpn,
  input  logic [PW-1:0]   wr_ppn,
  input  logic [SZ_W-1:0] wr_size,
  input  logic [TW-1:0]   lk_vpn,
  output logic            match,
  output logic [PW-1:0]   pa_hi
);

  logic            valid_q;
  logic [TW-1:0]   vpn_q;
  logic [PW-1:0]   ppn_q;
  logic [SZ_W-1:0] sz_q;
  logic [TW-1:0]   diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  valid_q <= 1'b0;
    else if (we) valid_q <= wr_valid;
  end

  // Datapath fields need no reset: they are qualified by valid_q.
  always_ff @(posedge clk) begin
    if (we) begin
      vpn_q <= wr_vpn;
      ppn_q <= wr_ppn;
      sz_q  <= wr_size;
    end
  end

  // Bits inside the page are excluded from the tag compare and
  // taken from the lookup address on translation.
  always_comb begin
    diff  = lk_vpn ^ vpn_q;
    pa_hi = ppn_q;
    for (int k = 0; k < MAXC; k++) begin
      if (k < int'(sz_q)) begin
        diff[k]  = 1'b0;
        pa_hi[k] = lk_vpn[k];
      end
    end
  end

  assign match = valid_q && (diff == '0);

endmodule

// File: rtl/tlb_age_lru.sv
module tlb_age_lru #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] lru_idx
);

  logic [IDX_W-1:0] age_q [N];
  logic [IDX_W-1:0] age_d [N];
  logic [IDX_W-1:0] ref_age;

  assign ref_age = age_q[touch_idx];

  // Ages form a permutation of 0..N-1; age 0 is most recent.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      age_d[i] = age_q[i];
      if (IDX_W'(i) == touch_idx)  age_d[i] = '0;
      else if (age_q[i] < ref_age) age_d[i] = age_q[i] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) age_q[i] <= age_d[i];
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == IDX_W'(N - 1)) lru_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int NUM_ENTRIES   = 64,
  parameter int VA_W          = 32,
  parameter int PA_W          = 32,
  parameter int MIN_PAGE_LOG2 = 10,
  parameter int MAX_PAGE_LOG2 = 13,
  localparam int IDX_W = tlb_pkg::enc_bits(NUM_ENTRIES),
  localparam int MAXC  = MAX_PAGE_LOG2 - MIN_PAGE_LOG2,
  localparam int SZ_W  = tlb_pkg::enc_bits(MAXC + 1),
  localparam int TW    = VA_W - MIN_PAGE_LOG2,
  localparam int PW    = PA_W - MIN_PAGE_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_va,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_mhit,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             miss_pend,
  output logic [VA_W-1:0]  fault_va,
  input  logic             miss_ack,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [TW-1:0]    wr_vpn,
  input  logic [PW-1:0]    wr_ppn,
  input  logic [SZ_W-1:0]  wr_size,
  output logic [IDX_W-1:0] lru_idx
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync = rst_sync_q[1];

  // Saturate size codes beyond the largest supported page.
  logic [SZ_W-1:0] wr_size_c;
  assign wr_size_c = (int'(wr_size) > MAXC) ? SZ_W'(MAXC) : wr_size;

  logic [NUM_ENTRIES-1:0] match;
  logic [PW-1:0]          ent_pa [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    tlb_entry #(
      .TW(TW), .PW(PW), .SZ_W(SZ_W), .MAXC(MAXC)
    ) u_ent (
      .clk     (clk),
      .rst_n   (rst_sync),
      .we      (wr_en && (wr_idx == IDX_W'(g))),
      .wr_valid(wr_valid),
      .wr_vpn  (wr_vpn),
      .wr_ppn  (wr_ppn),
      .wr_size (wr_size_c),
      .lk_vpn  (lk_va[VA_W-1:MIN_PAGE_LOG2]),
      .match   (match[g]),
      .pa_hi   (ent_pa[g])
    );
  end

  // Match reduction: count, encoded index and selected page.
  logic [IDX_W:0]   hit_cnt;
  logic [IDX_W-1:0] hit_idx;
  logic [PW-1:0]    pa_sel;
  logic             one_hit, no_hit, many_hit;

  always_comb begin
    hit_cnt = '0;
    hit_idx = '0;
    pa_sel  = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      hit_cnt = hit_cnt + {{IDX_W{1'b0}}, match[i]};
      if (match[i]) hit_idx = hit_idx | IDX_W'(i);
      pa_sel = pa_sel | (ent_pa[i] & {PW{match[i]}});
    end
  end

  assign one_hit  = (hit_cnt == (IDX_W+1)'(1));
  assign no_hit   = (hit_cnt == '0);
  assign many_hit = !one_hit && !no_hit;

  // Response stage: next state.
  logic            rsp_valid_d, rsp_hit_d, rsp_mhit_d;
  logic [PA_W-1:0] rsp_pa_d;
  logic            rsp_valid_q, rsp_hit_q, rsp_mhit_q;
  logic [PA_W-1:0] rsp_pa_q;

  always_comb begin
    rsp_valid_d = lk_req;
    rsp_hit_d   = lk_req && one_hit;
    rsp_mhit_d  = lk_req && many_hit;
    rsp_pa_d    = one_hit ? {pa_sel, lk_va[MIN_PAGE_LOG2-1:0]} : '0;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_mhit_q  <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      rsp_mhit_q  <= rsp_mhit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_req) rsp_pa_q <= rsp_pa_d;
  end

  // Miss trap: next state.
  logic miss_now, pend_d, pend_q, fault_ld;
  logic [VA_W-1:0] fault_q;

  always_comb begin
    miss_now = lk_req && no_hit;
    pend_d   = miss_now || (pend_q && !miss_ack);
    fault_ld = miss_now && (!pend_q || miss_ack);
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) pend_q <= 1'b0;
    else           pend_q <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (fault_ld) fault_q <= lk_va;
  end

  // Recency: a write has priority over a hit in the same cycle.
  logic             touch_en;
  logic [IDX_W-1:0] touch_idx;

  assign touch_en  = wr_en || (lk_req && one_hit);
  assign touch_idx = wr_en ? wr_idx : hit_idx;

  tlb_age_lru #(
    .N(NUM_ENTRIES), .IDX_W(IDX_W)
  ) u_lru (
    .clk      (clk),
    .rst_n    (rst_sync),
    .touch_en (touch_en),
    .touch_idx(touch_idx),
    .lru_idx  (lru_idx)
  );

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_mhit  = rsp_mhit_q;
  assign rsp_pa    = rsp_valid_q ? rsp_pa_q : '0;
  assign miss_pend = pend_q;
  assign fault_va  = fault_q;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_s,
  input logic             lk_req,
  input logic             miss_ack,
  input logic             wr_en,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_mhit,
  input logic             miss_pend,
  input logic [VA_W-1:0]  fault_va,
  input logic [IDX_W-1:0] lru_idx
);

  // Set one cycle after reset release so $past never reaches into reset.
  logic past_ok;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_resp_timing_r2: assert property (@(posedge clk) disable iff (!rst_s)
    past_ok |-> (rsp_valid == $past(lk_req)));

  p_hit_mhit_excl_r7: assert property (@(posedge clk) disable iff (!rst_s)
    !(rsp_hit && rsp_mhit));

  p_miss_raises_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (rsp_valid && !rsp_hit && !rsp_mhit) |-> miss_pend);

  p_fault_hold_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (past_ok && miss_pend && $past(miss_pend) && !$past(miss_ack)) |-> $stable(fault_va));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (past_ok && $past(miss_ack) && !$past(lk_req)) |-> !miss_pend);

  p_lru_idle_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (past_ok && !$past(wr_en) && !$past(lk_req)) |-> $stable(lru_idx));

endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_s    (rst_sync),
  .lk_req   (lk_req),
  .miss_ack (miss_ack),
  .wr_en    (wr_en),
  .rsp_valid(rsp_valid),
  .rsp_hit  (rsp_hit),
  .rsp_mhit (rsp_mhit),
  .miss_pend(miss_pend),
  .fault_va (fault_va),
  .lru_idx  (lru_idx)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;

  localparam int N = 64;

  logic        clk;
  logic        rst_n;
  logic        lk_req;
  logic [31:0] lk_va;
  logic        rsp_valid, rsp_hit, rsp_mhit;
  logic [31:0] rsp_pa;
  logic        miss_pend;
  logic [31:0] fault_va;
  logic        miss_ack;
  logic        wr_en;
  logic [5:0]  wr_idx;
  logic        wr_valid;
  logic [21:0] wr_vpn, wr_ppn;
  logic [1:0]  wr_size;
  logic [5:0]  lru_idx;

  int n_chk  = 0;
  int n_fail = 0;
  int rank [N];

  tlb_xlate u_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_mhit(rsp_mhit),
    .rsp_pa(rsp_pa), .miss_pend(miss_pend), .fault_va(fault_va),
    .miss_ack(miss_ack), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_valid(wr_valid), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
    .wr_size(wr_size), .lru_idx(lru_idx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  // Recency model: rank 0 is most recent.
  task automatic m_touch(input int idx);
    int r;
    r = rank[idx];
    for (int j = 0; j < N; j++) if (rank[j] < r) rank[j]++;
    rank[idx] = 0;
  endtask

  function automatic logic [31:0] m_lru();
    logic [31:0] res;
    res = '0;
    for (int j = 0; j < N; j++) if (rank[j] == N - 1) res = j;
    return res;
  endfunction

  task automatic step(input logic lk, input logic [31:0] va, input logic we,
                      input int idx, input logic v, input logic [21:0] vpn,
                      input logic [21:0] ppn, input logic [1:0] sz, input logic ack);
    @(negedge clk);
    lk_req = lk; lk_va = va; wr_en = we; wr_idx = 6'(idx);
    wr_valid = v; wr_vpn = vpn; wr_ppn = ppn; wr_size = sz; miss_ack = ack;
    @(posedge clk);
    #1;
    lk_req = 1'b0; wr_en = 1'b0; miss_ack = 1'b0;
  endtask

  task automatic wr(input int idx, input logic v, input logic [21:0] vpn,
                    input logic [21:0] ppn, input logic [1:0] sz);
    step(1'b0, 32'h0, 1'b1, idx, v, vpn, ppn, sz, 1'b0);
    m_touch(idx);
  endtask

  task automatic lk(input logic [31:0] va);
    step(1'b1, va, 1'b0, 0, 1'b0, 22'h0, 22'h0, 2'd0, 1'b0);
  endtask

  task automatic ack();
    step(1'b0, 32'h0, 1'b0, 0, 1'b0, 22'h0, 22'h0, 2'd0, 1'b1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; lk_req = 1'b0; lk_va = '0; miss_ack = 1'b0; wr_en = 1'b0;
    wr_idx = '0; wr_valid = 1'b0; wr_vpn = '0; wr_ppn = '0; wr_size = '0;
    for (int i = 0; i < N; i++) rank[i] = i;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 lru in reset", 32'(lru_idx), 32'd63);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 miss_pend", 32'(miss_pend), 0);
    chk("R1 lru", 32'(lru_idx), 32'd63);
  endtask

  task automatic t_miss();
    lk(32'h1234_5678);
    chk("R2 rsp_valid", 32'(rsp_valid), 1);
    chk("R4 hit", 32'(rsp_hit), 0);
    chk("R4 mhit", 32'(rsp_mhit), 0);
    chk("R4 pa", rsp_pa, 0);
    chk("R4 miss_pend", 32'(miss_pend), 1);
    chk("R4 fault_va", fault_va, 32'h1234_5678);
    lk(32'h5555_0000);
    chk("R5 fault held", fault_va, 32'h1234_5678);
    chk("R5 pend held", 32'(miss_pend), 1);
    ack();
    chk("R5 ack clears", 32'(miss_pend), 0);
    chk("R8 lru after misses", 32'(lru_idx), m_lru());
  endtask

  task automatic t_basic();
    wr(5, 1'b1, 22'h1000, 22'h20_0000, 2'd0);
    chk("R8 lru after write", 32'(lru_idx), m_lru());
    lk(32'h0040_0123); m_touch(5);
    chk("R2 hit", 32'(rsp_hit), 1);
    chk("R2 pa", rsp_pa, 32'h8000_0123);
    lk(32'h0040_0400);
    chk("R3 1KB page bound miss", 32'(rsp_hit), 0);
    ack();
  endtask

  task automatic t_sizes();
    wr(6, 1'b1, 22'h4000, 22'h8_0000, 2'd3);
    lk(32'h0100_1ABC); m_touch(6);
    chk("R3 8KB hit", 32'(rsp_hit), 1);
    chk("R3 8KB pa", rsp_pa, 32'h2000_1ABC);
    lk(32'h0100_2000);
    chk("R3 8KB bound miss", 32'(miss_pend), 1);
    ack();
    wr(7, 1'b1, 22'h8002, 22'hC_0003, 2'd2);
    lk(32'h0200_0345); m_touch(7);
    chk("R3 4KB hit low tag bits ignored", 32'(rsp_hit), 1);
    chk("R3 4KB pa low ppn bits ignored", rsp_pa, 32'h3000_0345);
    chk("R8 lru", 32'(lru_idx), m_lru());
  endtask

  task automatic t_invalidate();
    wr(5, 1'b0, 22'h1000, 22'h20_0000, 2'd0);
    lk(32'h0040_0123);
    chk("R6 invalidated misses", 32'(rsp_hit), 0);
    chk("R6 invalidated raises miss", 32'(miss_pend), 1);
    ack();
  endtask

  task automatic t_multi();
    wr(10, 1'b1, 22'h1_4000, 22'h100, 2'd0);
    wr(11, 1'b1, 22'h1_4000, 22'h200, 2'd0);
    lk(32'h0500_0010);
    chk("R7 mhit", 32'(rsp_mhit), 1);
    chk("R7 no hit", 32'(rsp_hit), 0);
    chk("R7 pa zero", rsp_pa, 0);
    chk("R7 no miss", 32'(miss_pend), 0);
    chk("R8 multi-hit no touch", 32'(lru_idx), m_lru());
  endtask

  task automatic t_write_during_lookup();
    step(1'b1, 32'h0100_0004, 1'b1, 6, 1'b1, 22'h4000, 22'h9_0000, 2'd3, 1'b0);
    m_touch(6);
    chk("R6 same-cycle old hit", 32'(rsp_hit), 1);
    chk("R6 same-cycle old pa", rsp_pa, 32'h2000_0004);
    lk(32'h0100_0004); m_touch(6);
    chk("R6 new pa visible", rsp_pa, 32'h2400_0004);
  endtask

  task automatic t_ack_collide();
    lk(32'h6000_0000);
    chk("R4 pend", 32'(miss_pend), 1);
    step(1'b1, 32'h6100_0000, 1'b0, 0, 1'b0, 22'h0, 22'h0, 2'd0, 1'b1);
    chk("R10 pend stays", 32'(miss_pend), 1);
    chk("R10 new fault", fault_va, 32'h6100_0000);
    ack();
    chk("R5 cleared", 32'(miss_pend), 0);
  endtask

  task automatic t_fill_lru();
    for (int i = 0; i < N; i++) wr(i, 1'b1, 22'h3_0000 + 22'(i), 22'h1000 + 22'(i), 2'd0);
    chk("R8 fill order", 32'(lru_idx), 0);
    lk(32'h0C00_0000); m_touch(0);
    chk("R2 fill hit pa", rsp_pa, 32'h0040_0000);
    chk("R8 hit touches", 32'(lru_idx), 1);
    step(1'b1, 32'h0C00_0400, 1'b1, 40, 1'b1, 22'h3_0028, 22'h1028, 2'd0, 1'b0);
    m_touch(40);
    chk("R9 hit pa", rsp_pa, 32'h0040_0400);
    chk("R9 only write touched", 32'(lru_idx), 1);
    lk(32'h7000_0000);
    chk("R8 miss no touch", 32'(lru_idx), m_lru());
    ack();
  endtask

  initial begin
    t_reset();
    t_miss();
    t_basic();
    t_sizes();
    t_invalidate();
    t_multi();
    t_write_during_lookup();
    t_ack_collide();
    t_fill_lru();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule